// File: doc/BRIEF.md
# Event-Triggered Sync Counter Queue

This block lets software arm hardware-driven counter increments. A register write states "when trigger condition C next fires, add one to counter N". The request waits in a two-entry queue owned by condition C. Each condition has a one-cycle event input. When that event fires and the queue holds a request, the oldest request leaves the queue and the counter it names goes up by one. Software then reads the counters to learn which hardware events have completed.

Each capture port p has two conditions. Its frame-start condition is code 5+4p and its memory-write-acknowledge-done condition is code 7+4p. With six ports the block keeps queues for codes 0 to 27. A control bit decides what happens when a request meets a full queue. The register port can hold its ready signal low until space frees, or the block can throw the request away and set a sticky error bit for that condition. A separate strobe lets software add one to any counter directly.

Top module: `evt_sync_queue`

## Requirements
- R1: A write to word address 0x00 is a request. Bits 15:8 carry the condition code and bits 4:0 carry the counter index. The request joins the queue of that condition.
- R2: The event input bit k belongs to condition code k. Port p uses code 5+4p for frame start and code 7+4p for write-acknowledge-done. With six ports, codes 0 to 27 have queues. A request whose code is 28 or higher is ignored: it does not stall and sets no error.
- R3: Each queue holds two requests and releases them oldest first. An event on a non-empty queue retires one request and adds one to the counter that request names.
- R4: An event whose queue is empty is ignored and changes no counter.
- R5: The control register is at word address 0x01. Bit 8 is the no-stall bit and it reads back there. All other bits read as zero.
- R6: With no-stall set, a request to a full queue (with no event in the same cycle) is discarded without stalling, and error bit [code] is set.
- R7: With no-stall clear, a request to a full queue holds bus_ready low. The request is accepted in the cycle an event for that condition frees a slot.
- R8: A request and an event on the same queue in the same cycle both take effect, even when the queue is full. There is no stall and no error.
- R9: A software increment strobe adds one to the counter it selects. If it coincides with an event increment of the same counter, that counter rises by two.
- R10: The error register is at word address 0x02, with bit position equal to the condition code. Writing ones clears the corresponding bits. Writing zeros leaves bits unchanged.
- R11: Counter n (32 bits) reads at word address 0x20+n. Reads are combinational and never stall.
- R12: Reset clears all queues, all counters, the error register and the no-stall bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Register access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Access completes at this edge when high |
| bus_rdata | output | 32 | Read data for bus_addr |
| cond_evt | input | 28 | One-cycle event pulse per condition code |
| sw_inc_valid | input | 1 | Direct counter increment strobe |
| sw_inc_idx | input | 5 | Counter selected by the strobe |

## Verification
The assertions take for granted two things about the inputs. First, the initiator holds a write steady while bus_ready is low, so a stall only ever stems from a request write. Second, each event is a level sampled once per clock, so occupancy moves by at most one step per cycle. The stimulus follows both rules. Accesses are driven on the falling edge and held until a sampled ready, and every event lasts exactly one cycle. The stimulus never pushes to a condition while an unrelated write is pending. Under these rules, an event on an empty queue without a request in the same cycle must leave that queue empty.

// File: rtl/evt_sync_queue.sv
module evt_sync_queue #(
  parameter int NUM_PORTS = 6,
  parameter int NUM_CNT   = 32,
  parameter int CNT_W     = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_valid,
  input  logic                       bus_write,
  input  logic [$clog2(NUM_CNT):0]   bus_addr,
  input  logic [31:0]                bus_wdata,
  output logic                       bus_ready,
  output logic [31:0]                bus_rdata,
  input  logic [4*NUM_PORTS+3:0]     cond_evt,
  input  logic                       sw_inc_valid,
  input  logic [$clog2(NUM_CNT)-1:0] sw_inc_idx
);
  localparam int NUM_COND = 4 * NUM_PORTS + 4;
  localparam int IDX_W    = $clog2(NUM_CNT);
  localparam int ADDR_W   = IDX_W + 1;
  localparam int INC_W    = $clog2(NUM_COND + 2);
  localparam logic [ADDR_W-1:0] A_PUSH = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_ERR  = ADDR_W'(2);
  localparam logic [7:0]        NC8    = 8'(NUM_COND);

  logic                             nostall;
  logic [NUM_COND-1:0]              err_q, full, pop, push, blocked, clr;
  logic [NUM_COND-1:0][1:0]         occ;
  logic [NUM_COND-1:0][IDX_W-1:0]   head, tail;
  logic [CNT_W-1:0]                 cnt [NUM_CNT];
  logic [INC_W-1:0]                 inc [NUM_CNT];

  wire             wr       = bus_valid && bus_write;
  wire [7:0]       req_code = bus_wdata[15:8];
  wire [IDX_W-1:0] req_idx  = bus_wdata[IDX_W-1:0];
  wire             push_req = wr && bus_addr == A_PUSH && req_code < NC8;

  assign bus_ready = !(|blocked) || nostall;
  assign clr       = (wr && bus_addr == A_ERR) ? bus_wdata[NUM_COND-1:0] : '0;

  for (genvar c = 0; c < NUM_COND; c++) begin : g_q
    wire hit = push_req && req_code == 8'(c);
    assign full[c]    = occ[c] == 2'd2;
    assign pop[c]     = cond_evt[c] && occ[c] != 2'd0;
    assign push[c]    = hit && (!full[c] || pop[c]);
    assign blocked[c] = hit && full[c] && !pop[c];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        occ[c]  <= '0;
        head[c] <= '0;
        tail[c] <= '0;
      end else begin
        unique case ({push[c], pop[c]})
          2'b01: begin
            head[c] <= tail[c];
            occ[c]  <= occ[c] - 2'd1;
          end
          2'b10: begin
            if (occ[c] == 2'd0) head[c] <= req_idx;
            else                tail[c] <= req_idx;
            occ[c] <= occ[c] + 2'd1;
          end
          2'b11: begin
            if (occ[c] == 2'd1) head[c] <= req_idx;
            else begin
              head[c] <= tail[c];
              tail[c] <= req_idx;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    for (int n = 0; n < NUM_CNT; n++) begin
      inc[n] = INC_W'(sw_inc_valid && sw_inc_idx == IDX_W'(n));
      for (int c = 0; c < NUM_COND; c++)
        inc[n] = inc[n] + INC_W'(pop[c] && head[c] == IDX_W'(n));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int n = 0; n < NUM_CNT; n++) cnt[n] <= '0;
      nostall <= 1'b0;
      err_q   <= '0;
    end else begin
      for (int n = 0; n < NUM_CNT; n++) cnt[n] <= cnt[n] + CNT_W'(inc[n]);
      if (wr && bus_addr == A_CTRL) nostall <= bus_wdata[8];
      err_q <= (err_q & ~clr) | (blocked & {NUM_COND{nostall}});
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr[ADDR_W-1])      bus_rdata = 32'(cnt[bus_addr[IDX_W-1:0]]);
    else if (bus_addr == A_CTRL) bus_rdata[8] = nostall;
    else if (bus_addr == A_ERR)  bus_rdata = 32'(err_q);
  end
endmodule

// File: rtl/evt_sync_queue_chk.sv
module evt_sync_queue_chk #(
  parameter int NUM_COND = 28,
  parameter int ADDR_W   = 6
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     bus_valid,
  input logic                     bus_write,
  input logic [ADDR_W-1:0]        bus_addr,
  input logic [31:0]              bus_wdata,
  input logic                     bus_ready,
  input logic                     nostall,
  input logic [NUM_COND-1:0][1:0] occ,
  input logic [NUM_COND-1:0]      err_q
);
  wire push_wr = bus_valid && bus_write && bus_addr == '0;
  wire err_wr  = bus_valid && bus_write && bus_addr == ADDR_W'(2);

  p_stall_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ready |-> push_wr && !nostall);

  for (genvar c = 0; c < NUM_COND; c++) begin : g_c
    p_occ_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      occ[c] <= 2'd2);
    p_empty_evt_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (occ[c] == 2'd0 && !push_wr) |=> occ[c] == 2'd0);
    p_single_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ##1 (occ[c] <= $past(occ[c]) + 2'd1) && (occ[c] + 2'd1 >= $past(occ[c])));
    p_err_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (err_q[c] && !(err_wr && bus_wdata[c])) |=> err_q[c]);
    p_err_nostall_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ##1 $rose(err_q[c]) |-> $past(nostall));
  end
endmodule

bind evt_sync_queue evt_sync_queue_chk #(.NUM_COND(NUM_COND), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
  .nostall(nostall), .occ(occ), .err_q(err_q)
);

// File: tb/test_evt_sync_queue.sv
`timescale 1ns/1ps
module test_evt_sync_queue;
  logic        clk = 0, rst_n = 0;
  logic        bus_valid = 0, bus_write = 0;
  logic [5:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic        bus_ready;
  logic [31:0] bus_rdata;
  logic [27:0] cond_evt = '0;
  logic        sw_inc_valid = 0;
  logic [4:0]  sw_inc_idx = 0;

  int n_chk = 0, n_bad = 0;
  logic [31:0] exp_cnt [32];
  logic        done = 0;

  always #2.5 clk = ~clk;

  evt_sync_queue i_evt_sync_queue (.*);

  function automatic logic [31:0] req(input int code, input int idx);
    return {16'h0, 8'(code), 3'b0, 5'(idx)};
  endfunction

  task automatic chk(input string r, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", r, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    #1;
    while (!bus_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic bus_rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = a;
    #1 d = bus_rdata;
    bus_valid = 0;
  endtask

  task automatic pulse(input int c);
    @(negedge clk); cond_evt[c] = 1'b1;
    @(posedge clk); #1 cond_evt = '0;
  endtask

  task automatic chk_cnt(input string r, input int n);
    logic [31:0] v;
    bus_rd(6'(32 + n), v);
    chk(r, v, exp_cnt[n]);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    for (int n = 0; n < 32; n++) exp_cnt[n] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R12 reset state, R5 control readback
    bus_rd(6'd1, v); chk("R12 ctrl", v, 0);
    bus_rd(6'd2, v); chk("R12 err", v, 0);
    for (int n = 0; n < 32; n++) chk_cnt("R12 R11 counter", n);
    bus_wr(6'd1, 32'hFFFF_FFFF);
    bus_rd(6'd1, v); chk("R5 ctrl set", v, 32'h100);
    bus_wr(6'd1, 32'h0);
    bus_rd(6'd1, v); chk("R5 ctrl clear", v, 0);

    // R1 R2 R3 R4 sweep of every port and event type
    for (int p = 0; p < 6; p++) begin
      for (int t = 0; t < 2; t++) begin
        int code, a, b;
        code = 5 + 4 * p + 2 * t;
        a = code % 32;
        b = (code + 7) % 32;
        bus_wr(6'd0, req(code, a));
        bus_wr(6'd0, req(code, b));
        pulse(code); exp_cnt[a]++;
        chk_cnt("R3 oldest first", a);
        chk_cnt("R1 second waits", b);
        pulse(code); exp_cnt[b]++;
        chk_cnt("R3 second retire", b);
        pulse(code);
        chk_cnt("R4 empty event a", a);
        chk_cnt("R4 empty event b", b);
      end
    end

    // R7 stall until event frees a slot
    bus_wr(6'd0, req(13, 3));
    bus_wr(6'd0, req(13, 4));
    fork
      bus_wr(6'd0, req(13, 5));
      begin
        repeat (4) @(negedge clk);
        #1 chk("R7 ready low while full", bus_ready, 0);
        pulse(13);
      end
    join
    exp_cnt[3]++;
    chk_cnt("R7 pop during stall", 3);
    pulse(13); exp_cnt[4]++; chk_cnt("R7 next entry", 4);
    pulse(13); exp_cnt[5]++; chk_cnt("R7 stalled request kept", 5);

    // R6 R10 drop in no-stall mode
    bus_wr(6'd1, 32'h100);
    bus_wr(6'd0, req(9, 1));
    bus_wr(6'd0, req(9, 2));
    bus_wr(6'd0, req(9, 6));
    bus_rd(6'd2, v); chk("R6 error bit", v, 32'h1 << 9);
    bus_wr(6'd2, 32'h0);
    bus_rd(6'd2, v); chk("R10 zero write keeps", v, 32'h1 << 9);
    pulse(9); exp_cnt[1]++; chk_cnt("R6 first kept", 1);
    pulse(9); exp_cnt[2]++; chk_cnt("R6 second kept", 2);
    pulse(9); chk_cnt("R6 dropped request", 6);
    bus_wr(6'd2, 32'h1 << 9);
    bus_rd(6'd2, v); chk("R10 w1c", v, 0);

    // R2 out-of-range code ignored
    bus_wr(6'd0, req(40, 7));
    bus_wr(6'd0, req(40, 7));
    bus_wr(6'd0, req(40, 7));
    bus_rd(6'd2, v); chk("R2 high code no error", v, 0);
    pulse(0); chk_cnt("R2 R4 unarmed event", 0);
    chk_cnt("R2 high code no count", 7);

    // R8 push and pop together on full queue
    bus_wr(6'd0, req(7, 10));
    bus_wr(6'd0, req(7, 11));
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = 0; bus_wdata = req(7, 12);
    cond_evt[7] = 1'b1;
    #1 chk("R8 no stall", bus_ready, 1);
    @(posedge clk); #1;
    bus_valid = 0; bus_write = 0; cond_evt = '0;
    exp_cnt[10]++;
    chk_cnt("R8 pop applied", 10);
    bus_rd(6'd2, v); chk("R8 no error", v, 0);
    pulse(7); exp_cnt[11]++; chk_cnt("R8 order kept", 11);
    pulse(7); exp_cnt[12]++; chk_cnt("R8 push applied", 12);

    // R9 software increment alone and coinciding
    @(negedge clk); sw_inc_valid = 1; sw_inc_idx = 31;
    @(posedge clk); #1 sw_inc_valid = 0;
    exp_cnt[31]++; chk_cnt("R9 sw only", 31);
    bus_wr(6'd0, req(21, 20));
    @(negedge clk); sw_inc_valid = 1; sw_inc_idx = 20; cond_evt[21] = 1'b1;
    @(posedge clk); #1 sw_inc_valid = 0; cond_evt = '0;
    exp_cnt[20] += 2; chk_cnt("R9 double increment", 20);

    for (int n = 0; n < 32; n++) chk_cnt("R11 final counters", n);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule